// File: doc/BRIEF.md
# Command-Driven Video Sync Sequencer

This block turns a stream of 32-bit words into a raster signal: eight colour bits plus horizontal and vertical sync pins. The stream mixes two kinds of word. A command word picks a segment type and a loop count. Raw pixel words carry four 8-bit pixels. The block holds no line or frame counters of its own. Every porch, pulse and visible run lasts exactly as long as the commands in the stream dictate. Software, or a DMA engine, builds the command lists once and replays them line after line.

The sequencer advances on a clock enable that fires every `CLK_DIV` system clocks. A one-word holding register sits between the ready/valid input and the sequencer. It refills between two enables, so the next command or pixel word is already in place when the sequencer needs it. The next command is read on the second-to-last tick of the running segment. This means the fetch time is counted inside each segment's length, and consecutive segments follow one another with no gap.

If a word is needed and the holding register is empty, the sequencer freezes with its outputs held and raises a sticky underflow flag. Only the clear input drops that flag.

Top module: `vidseq_top`

## Requirements
- R1: While reset is asserted and after its release, colour reads 0, both sync pins read 1, the underflow flag reads 0 and the input is ready.
- R2: In a command word, bits 31:27 select the segment and bits 26:0 hold a count N. The select codes are: 0 blank, 1 horizontal sync, 2 vertical sync, 3 both syncs, 4 pixel output.
- R3: A sync segment drives low the pin or pins its code names, for N+3 ticks. The other sync pin stays high, and the colour keeps the value it had before the segment.
- R4: A blank segment lasts N+4 ticks, with colour forced to 0 and both sync pins high.
- R5: A pixel segment shows N+2 pixels, each for exactly 5 ticks, with both sync pins high. Each pixel word supplies four pixels starting from its least significant byte, and the next word is taken after its fourth pixel.
- R6: One tick is `CLK_DIV` system clocks (default 2). Segment lengths on the pins are therefore tick counts times `CLK_DIV`.
- R7: When a needed word is missing, all outputs and timing hold until it arrives, and the underflow flag goes to 1. The flag stays 1 until a cycle with `underflowClr` high.
- R8: Select codes 5 to 31 behave as a blank segment: colour 0, sync pins high, N+4 ticks.
- R9: A line made of a horizontal sync with N=237, a blank with N=117, a pixel run with N=318 and a blank with N=37 repeats every 2002 ticks. Its visible pixels start 361 ticks after the sync falls.
- R10: After reset, waiting for the first command does not set the underflow flag and leaves the pins idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inWord | input | 32 | Command or pixel word |
| inValid | input | 1 | inWord holds a word |
| inReady | output | 1 | Holding register can accept a word |
| colourOut | output | 8 | Colour pins |
| hsyncN | output | 1 | Horizontal sync, low during the pulse |
| vsyncN | output | 1 | Vertical sync, low during the pulse |
| underflow | output | 1 | Sticky flag: a word was missing when needed |
| underflowClr | input | 1 | Clears the underflow flag |

## Verification
The bench measures each segment's length on the pins in clocks, starting from the first sync fall. Segment lengths that are off by one show up as a shifted edge: for example, a pixel segment that counts its fetch overhead wrongly, or a final pixel stretched by the command fetch. The bench also samples pixel colours at every pixel boundary. A wrong unpacking order or a missed word reload shows up as a wrong byte there. It checks that colour stays put during sync-only segments and is cleared by blanking and by unknown codes. A design that treated those codes as sync, or left stale colour, would fail those checks. Finally, the bench starves the input mid-pulse and confirms that the pulse stretches rather than ends, and that the flag survives until it is cleared.

// File: rtl/vidseq_pkg.sv
package vidseq_pkg;

  localparam int SEL_W = 5;

  typedef enum logic [2:0] {
    SEG_BLANK,
    SEG_HS,
    SEG_VS,
    SEG_HV,
    SEG_PIX
  } seg_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic pop;
    logic loadPix;
    logic nextPix;
    logic setSync;
    logic hsOn;
    logic vsOn;
    logic clrColour;
  } dpCtl_t;

  function automatic seg_e decodeSel(input logic [SEL_W-1:0] sel);
    case (sel)
      5'd1:    return SEG_HS;
      5'd2:    return SEG_VS;
      5'd3:    return SEG_HV;
      5'd4:    return SEG_PIX;
      default: return SEG_BLANK;
    endcase
  endfunction

endpackage

// File: rtl/vidseq_tick.sv
module vidseq_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic ce
);
  localparam int CW = $clog2(DIV > 1 ? DIV : 2);
  localparam logic [CW-1:0] LAST = CW'(DIV > 1 ? DIV - 1 : 0);

  logic [CW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        divCnt <= '0;
    else if (DIV <= 1 || divCnt == LAST) divCnt <= '0;
    else                              divCnt <= divCnt + CW'(1);
  end

  assign ce = (DIV <= 1) || (divCnt == LAST);
endmodule

// File: rtl/vidseq_ctrl.sv
module vidseq_ctrl
  import vidseq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PIX_W     = 8,
  parameter int PIX_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce,
  input  logic              holdFull,
  input  logic [WORD_W-1:0] holdWord,
  input  logic              clrUnder,
  output dpCtl_t            ctl,
  output logic              underflow
);
  localparam int CNT_W       = WORD_W - SEL_W;
  localparam int LEN_W       = CNT_W + 3;
  localparam int PH_W        = $clog2(PIX_TICKS);
  localparam int PPW         = WORD_W / PIX_W;
  localparam int IDX_W       = $clog2(PPW);
  localparam int SYNC_EXTRA  = 3;
  localparam int BLANK_EXTRA = 4;
  localparam int PIX_EXTRA   = 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PPW - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(PIX_TICKS - 1);

  logic [LEN_W-1:0] cnt;      // ticks left in the running segment
  logic             booting;
  seg_e             curSeg, pendSeg;
  logic [CNT_W-1:0] pendN;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] byteIdx;

  logic atStart, needCmd, pixActive, pixEdge, needPixWord, starved, go;

  function automatic logic [LEN_W-1:0] segLen(input seg_e s, input logic [CNT_W-1:0] n);
    logic [LEN_W-1:0] nx;
    nx = LEN_W'(n);
    case (s)
      SEG_BLANK: return nx + LEN_W'(BLANK_EXTRA);
      SEG_PIX:   return (nx + LEN_W'(PIX_EXTRA)) * LEN_W'(PIX_TICKS);
      default:   return nx + LEN_W'(SYNC_EXTRA);
    endcase
  endfunction

  always_comb begin
    atStart     = (cnt == LEN_W'(1));
    needCmd     = ce && (cnt == LEN_W'(2));
    pixActive   = !booting && (curSeg == SEG_PIX);
    pixEdge     = ce && pixActive && !atStart && (phase == LAST_PH);
    needPixWord = (pixEdge && byteIdx == LAST_IDX) ||
                  (ce && atStart && pendSeg == SEG_PIX);
    starved     = (needCmd || needPixWord) && !holdFull;
    go          = ce && !starved;

    ctl           = '0;
    ctl.pop       = go && (needCmd || needPixWord);
    ctl.loadPix   = go && needPixWord;
    ctl.nextPix   = go && pixEdge && (byteIdx != LAST_IDX);
    ctl.setSync   = go && atStart;
    ctl.hsOn      = (pendSeg == SEG_HS) || (pendSeg == SEG_HV);
    ctl.vsOn      = (pendSeg == SEG_VS) || (pendSeg == SEG_HV);
    ctl.clrColour = go && atStart && (pendSeg == SEG_BLANK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= LEN_W'(2);
      booting   <= 1'b1;
      curSeg    <= SEG_BLANK;
      pendSeg   <= SEG_BLANK;
      pendN     <= '0;
      phase     <= '0;
      byteIdx   <= '0;
      underflow <= 1'b0;
    end else begin
      if (starved && !booting) underflow <= 1'b1;
      else if (clrUnder)       underflow <= 1'b0;

      if (go) begin
        if (atStart) begin
          curSeg  <= pendSeg;
          cnt     <= segLen(pendSeg, pendN);
          phase   <= '0;
          byteIdx <= '0;
        end else begin
          cnt <= cnt - LEN_W'(1);
          if (needCmd) begin
            pendSeg <= decodeSel(holdWord[WORD_W-1 -: SEL_W]);
            pendN   <= holdWord[CNT_W-1:0];
            booting <= 1'b0;
          end
          if (pixActive) begin
            if (phase == LAST_PH) begin
              phase   <= '0;
              byteIdx <= byteIdx + IDX_W'(1);
            end else begin
              phase <= phase + PH_W'(1);
            end
          end
        end
      end
    end
  end

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !clrUnder) |=> underflow);

  // R7
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ce && starved) |=> $stable(cnt));

  // R3
  len_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0);

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST_PH);
endmodule

// File: rtl/vidseq_dp.sv
module vidseq_dp
  import vidseq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output logic              inReady,
  input  dpCtl_t            ctl,
  output logic [WORD_W-1:0] holdWord,
  output logic              holdFull,
  output logic [PIX_W-1:0]  colour,
  output logic              hsAct,
  output logic              vsAct
);
  logic [WORD_W-1:0] shiftReg;

  assign inReady = !holdFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      holdFull <= 1'b0;
    end else if (ctl.pop) begin
      holdFull <= 1'b0;
    end else if (inValid && !holdFull) begin
      holdWord <= inWord;
      holdFull <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      colour   <= '0;
      hsAct    <= 1'b0;
      vsAct    <= 1'b0;
    end else begin
      if (ctl.loadPix) begin
        colour   <= holdWord[PIX_W-1:0];
        shiftReg <= holdWord >> PIX_W;
      end else if (ctl.nextPix) begin
        colour   <= shiftReg[PIX_W-1:0];
        shiftReg <= shiftReg >> PIX_W;
      end else if (ctl.clrColour) begin
        colour <= '0;
      end
      if (ctl.setSync) begin
        hsAct <= ctl.hsOn;
        vsAct <= ctl.vsOn;
      end
    end
  end

  // R7
  pop_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> holdFull);

  // R3
  sync_keeps_colour_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setSync && !ctl.loadPix && !ctl.clrColour) |=> $stable(colour));
endmodule

// File: rtl/vidseq_top.sv
module vidseq_top
  import vidseq_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int WORD_W    = 32,
  parameter int PIX_W     = 8,
  parameter int PIX_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output logic              inReady,
  output logic [PIX_W-1:0]  colourOut,
  output logic              hsyncN,
  output logic              vsyncN,
  output logic              underflow,
  input  logic              underflowClr
);
  logic              ce, holdFull, hsAct, vsAct;
  logic [WORD_W-1:0] holdWord;
  dpCtl_t            ctl;

  vidseq_tick #(.DIV(CLK_DIV)) uTick (
    .clk(clk), .rstN(rstN), .ce(ce)
  );

  vidseq_ctrl #(.WORD_W(WORD_W), .PIX_W(PIX_W), .PIX_TICKS(PIX_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .ce(ce), .holdFull(holdFull), .holdWord(holdWord),
    .clrUnder(underflowClr), .ctl(ctl), .underflow(underflow)
  );

  vidseq_dp #(.WORD_W(WORD_W), .PIX_W(PIX_W)) uDp (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid), .inReady(inReady),
    .ctl(ctl), .holdWord(holdWord), .holdFull(holdFull), .colour(colourOut),
    .hsAct(hsAct), .vsAct(vsAct)
  );

  // sync is active high inside, pins idle high
  assign hsyncN = ~hsAct;
  assign vsyncN = ~vsAct;
endmodule

// File: tb/tb_vidseq_top.sv
module tb_vidseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOGLEN     = 6000;
  localparam int QLEN       = 512;
  localparam int S_HS = 0, S_VS = 1, S_COL = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inWord = '0;
  logic        inValid = 1'b0;
  logic        underflowClr = 1'b0;
  wire         inReady, hsyncN, vsyncN, underflow;
  wire  [7:0]  colourOut;

  vidseq_top dut (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid), .inReady(inReady),
    .colourOut(colourOut), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .underflow(underflow), .underflowClr(underflowClr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0, nErr = 0;
  logic [31:0] q[QLEN];
  int head = 0, tail = 0;
  bit feedOn = 0, offered = 0;
  logic [7:0] trCol[LOGLEN];
  logic       trHs[LOGLEN];
  logic       trVs[LOGLEN];
  int tIdx = 0;

  // feeder: a word offered while inReady is high is taken at the next edge
  initial forever begin
    @(negedge clk);
    if (offered) head++;
    inValid = feedOn && (head < tail);
    inWord  = inValid ? q[head] : 32'h0;
    offered = inValid && inReady && rstN;
  end

  // trace of the pins, one sample per clock between edges
  initial forever begin
    @(negedge clk);
    if (tIdx < LOGLEN) begin
      trCol[tIdx] = colourOut;
      trHs[tIdx]  = hsyncN;
      trVs[tIdx]  = vsyncN;
      tIdx++;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErr++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    summary();
  end

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sig(int sel, int i);
    if (i < 0 || i >= LOGLEN) return -1;
    case (sel)
      S_HS:    return int'(trHs[i]);
      S_VS:    return int'(trVs[i]);
      default: return int'(trCol[i]);
    endcase
  endfunction

  function automatic int firstIdx(int sel, int val, int from);
    for (int i = from; i < LOGLEN; i++) if (sig(sel, i) == val) return i;
    return -1;
  endfunction

  function automatic int runLen(int sel, int val, int from);
    int n = 0;
    if (from < 0) return -1;
    for (int i = from; i < LOGLEN; i++) begin
      if (sig(sel, i) != val) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] cmd(int code, int n);
    return {code[4:0], n[26:0]};
  endfunction

  task automatic push(logic [31:0] w);
    q[tail] = w;
    tail++;
  endtask

  task automatic doReset();
    feedOn = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    head = 0;
    tail = 0;
  endtask

  task automatic release_run(int clocks);
    rstN = 1'b1;
    tIdx = 0;
    feedOn = 1;
    repeat (clocks) @(negedge clk);
  endtask

  // R1 reset state
  task automatic testReset();
    doReset();
    chk("R1", "colour in reset", colourOut, 0);
    chk("R1", "hsyncN in reset", hsyncN, 1);
    chk("R1", "vsyncN in reset", vsyncN, 1);
    chk("R1", "underflow in reset", underflow, 0);
    chk("R1", "inReady in reset", inReady, 1);
  endtask

  // R2 R3 R6: sync segment lengths and pin selection
  task automatic testSync();
    int a;
    doReset();
    push(cmd(1, 5)); push(cmd(0, 2)); push(cmd(2, 0));
    push(cmd(0, 0)); push(cmd(3, 1)); push(cmd(0, 200));
    release_run(700);
    a = firstIdx(S_HS, 0, 0);
    chk("R3", "hsync low clocks (N=5)", runLen(S_HS, 0, a), 16);
    chk("R6", "vsync high before vsync segment", runLen(S_VS, 1, a), 28);
    chk("R3", "hsync high across blank, vsync, blank", runLen(S_HS, 1, a + 16), 26);
    chk("R3", "vsync low clocks (N=0)", runLen(S_VS, 0, a + 28), 6);
    chk("R4", "vsync high in blank N=0", runLen(S_VS, 1, a + 34), 8);
    chk("R2", "both low, hsync clocks (code 3)", runLen(S_HS, 0, a + 42), 8);
    chk("R2", "both low, vsync clocks (code 3)", runLen(S_VS, 0, a + 42), 8);
  endtask

  // R5 R3 R4: pixel unpacking and colour behaviour around sync
  task automatic testPixels();
    int a;
    doReset();
    push(cmd(1, 1)); push(cmd(4, 6));
    push(32'h44332211); push(32'h88776655);
    push(cmd(1, 0)); push(cmd(0, 0)); push(cmd(0, 300));
    release_run(900);
    a = firstIdx(S_HS, 0, 0);
    chk("R5", "colour before pixels", sig(S_COL, a + 7), 0);
    for (int k = 0; k < 8; k++) begin
      chk("R5", $sformatf("pixel %0d first clock", k), sig(S_COL, a + 8 + 10 * k), 8'h11 * (k + 1));
      chk("R5", $sformatf("pixel %0d last clock", k), sig(S_COL, a + 17 + 10 * k), 8'h11 * (k + 1));
    end
    chk("R5", "first pixel width", runLen(S_COL, 8'h11, a + 8), 10);
    chk("R5", "hsync high during pixels", sig(S_HS, a + 8), 1);
    chk("R3", "hsync low after pixels", runLen(S_HS, 0, a + 88), 6);
    chk("R3", "colour held in sync start", sig(S_COL, a + 88), 8'h88);
    chk("R3", "colour held in sync end", sig(S_COL, a + 93), 8'h88);
    chk("R4", "blank clears colour", sig(S_COL, a + 94), 0);
  endtask

  // R8: unknown select acts as blank
  task automatic testUnknown();
    int a;
    doReset();
    push(cmd(1, 0)); push(cmd(4, 2)); push(32'hAABBCCDD);
    push(cmd(7, 2)); push(cmd(1, 0)); push(cmd(0, 300));
    release_run(900);
    a = firstIdx(S_HS, 0, 0);
    chk("R5", "low byte first", sig(S_COL, a + 6), 8'hDD);
    chk("R5", "fourth byte last", sig(S_COL, a + 36), 8'hAA);
    chk("R8", "code 7 clears colour", sig(S_COL, a + 46), 0);
    chk("R8", "code 7 keeps vsync high", sig(S_VS, a + 46), 1);
    chk("R8", "code 7 length (pixels + N+4)", runLen(S_HS, 1, a + 6), 52);
    chk("R8", "sync follows code 7", sig(S_HS, a + 58), 0);
  endtask

  // R7 R10: stall and sticky flag
  task automatic testUnderflow();
    doReset();
    release_run(40);
    chk("R10", "no underflow while booting", underflow, 0);
    chk("R10", "hsyncN idle while booting", hsyncN, 1);
    chk("R10", "colour idle while booting", colourOut, 0);
    push(cmd(1, 3));
    repeat (100) @(negedge clk);
    chk("R7", "underflow raised", underflow, 1);
    chk("R7", "hsync held low while starved", hsyncN, 0);
    push(cmd(0, 1000)); push(cmd(0, 1000));
    repeat (30) @(negedge clk);
    chk("R7", "resumes after word arrives", hsyncN, 1);
    chk("R7", "flag sticky after resume", underflow, 1);
    underflowClr = 1'b1;
    @(negedge clk);
    underflowClr = 1'b0;
    @(negedge clk);
    chk("R7", "flag cleared", underflow, 0);
  endtask

  // R9: full line timing
  task automatic testLine();
    int a, b;
    doReset();
    for (int ln = 0; ln < 2; ln++) begin
      push(cmd(1, 237)); push(cmd(0, 117)); push(cmd(4, 318));
      for (int w = 0; w < 80; w++) begin
        logic [31:0] word;
        for (int bb = 0; bb < 4; bb++) word[8*bb +: 8] = 8'((4 * w + bb + 1) & 255);
        push(word);
      end
      push(cmd(0, 37));
    end
    push(cmd(1, 237)); push(cmd(0, 2000));
    release_run(LOGLEN);
    a = firstIdx(S_HS, 0, 0);
    b = firstIdx(S_HS, 0, a + 480);
    chk("R9", "hsync pulse clocks", runLen(S_HS, 0, a), 480);
    chk("R9", "line period clocks", b - a, 4004);
    chk("R9", "dark before first pixel", sig(S_COL, a + 721), 0);
    chk("R9", "first pixel", sig(S_COL, a + 722), 1);
    chk("R9", "last pixel", sig(S_COL, a + 3921), 320 & 255);
    chk("R4", "front porch dark", sig(S_COL, a + 3922), 0);
  endtask

  initial begin
    testReset();
    testSync();
    testPixels();
    testUnknown();
    testUnderflow();
    testLine();
    summary();
  end
endmodule